// File: doc/BRIEF.md
# Serial Transmit Path with Pacing Flags

This block sends bytes as asynchronous serial frames of eight data bits, no parity and one stop bit. The line idles high, the data bits go out least significant bit first, and every bit lasts a fixed number of baud ticks. Software writes bytes with a one-cycle strobe. The write lands in one of two buffers, chosen by a mode input. With the mode input low, the buffer is a one-word holding register. With the mode input high, the buffer is an eight-entry first-in first-out queue. If the line is idle and the buffer is empty, a write skips the buffer and starts a frame on the next cycle.

The block drives the status flags that software uses to pace its writes:
- buffer empty
- queue not full
- queue empty
- queue threshold
- transfer complete
- a sticky overflow flag for dropped writes

Each of the five pacing flags has its own enable input. The interrupt output is the OR of every enabled flag. The complete flag only rises after the stop bit of a frame, and only if nothing is left to send.

The serialiser is a four-state machine: IDLE, START, DATA and STOP. It has these transitions:
- IDLE→START (load): a byte is offered while the line is idle.
- START→DATA (start-done): the last tick of the start bit.
- DATA→DATA (next-bit): the last tick of a data bit, before the eighth bit.
- DATA→STOP (bits-done): the last tick of the eighth data bit.
- STOP→START (chain): the last tick of the stop bit, while the buffer still holds a byte.
- STOP→IDLE (drain): the last tick of the stop bit, with the buffer empty.

Top module: `uart_tx_flags`

## Requirements
- R1: After reset the outputs hold these values: `txd`=1, `flag_empty`=1, `flag_notfull`=1, `flag_fifo_empty`=1, `flag_thr`=1, `flag_done`=1 and `flag_ovf`=0.
- R2: A frame has these parts, in order:
  - a low start bit
  - eight data bits, least significant bit first
  - a high stop bit

  Each bit lasts BIT_TICKS (16) cycles in which `baud_tick` is high. The frame does not advance while `baud_tick` is low.
- R3: A write made while the line is idle and the buffer is empty goes straight to the serialiser. `txd` goes low in the cycle after the write, and `flag_empty` stays 1.
- R4: With `fifo_mode`=0, a write made during a frame goes into the holding register, and `flag_empty` reads 0. That byte is sent directly after the current frame, and `flag_empty` then returns to 1.
- R5: With `fifo_mode`=0, a write is dropped if the holding register is already occupied.
- R6: With `fifo_mode`=1, writes made during a frame go into the queue and are sent in write order. `flag_notfull` stays 1 until the queue holds 8 bytes.
- R7: `flag_thr` is 1 while the number of free queue slots is at least the threshold set by `thr_sel`. The encoding is 0→1, 1→2, 2→4, 3→6, 4→7, and 5 to 7→8.
- R8: `flag_fifo_empty` is 1 exactly when the queue holds no byte.
- R9: `flag_done` rises only at the end of a stop bit after which nothing is buffered. It stays 0 between frames that are sent back to back. It reads 0 in the cycle after any accepted write.
- R10: `irq` is the OR of each pacing flag ANDed with its own enable input.
- R11: A write dropped by a full buffer (the queue or the holding register) is not sent. It sets `flag_ovf`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick | input | 1 | One-cycle baud tick |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to send |
| fifo_mode | input | 1 | 1 selects the queue, 0 the holding register |
| thr_sel | input | 3 | Threshold code for free queue slots |
| ie_empty | input | 1 | Enable for the buffer-empty interrupt |
| ie_notfull | input | 1 | Enable for the queue-not-full interrupt |
| ie_fifo_empty | input | 1 | Enable for the queue-empty interrupt |
| ie_thr | input | 1 | Enable for the threshold interrupt |
| ie_done | input | 1 | Enable for the transfer-complete interrupt |
| txd | output | 1 | Serial line |
| flag_empty | output | 1 | Buffer empty for the selected mode |
| flag_notfull | output | 1 | Queue not full |
| flag_fifo_empty | output | 1 | Queue empty |
| flag_thr | output | 1 | Free queue slots at or above the threshold |
| flag_done | output | 1 | Transfer complete |
| flag_ovf | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Combined masked interrupt |

## Verification
Each kind of internal fault shows at the ports in a known way and time:
- **Wrong bit counter or tick counter:** the decoded byte is wrong, or a sample lands outside its bit. This shows inside the first frame, within 160 ticks.
- **Lost or repeated queue entry:** the received stream differs from the accepted writes. This shows by the end of the drain of that burst.
- **Stale level or pointer state:** the flag readings taken at once after each burst do not match the count the bench predicts, and neither do the levels after draining.
- **Premature complete flag:** it shows as fewer received bytes than expected at the moment `flag_done` rises.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_STOP
    } sh_state_t;

    // Free-slot threshold for a given select code and queue depth.
    function automatic int unsigned thr_slots(input logic [2:0] sel, input int unsigned depth);
        int unsigned r;
        unique case (sel)
            3'd0:    r = depth / 8;
            3'd1:    r = depth / 4;
            3'd2:    r = depth / 2;
            3'd3:    r = (depth * 3) / 4;
            3'd4:    r = (depth * 7) / 8;
            default: r = depth;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [DW-1:0]                  din,
    input  logic                           pop,
    output logic [DW-1:0]                  dout,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // R6: writer never pushes into a full queue
    p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R8: reader never pops an empty queue
    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int DW        = 8,
    parameter int BIT_TICKS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_take,
    output logic          txd,
    output logic          busy,
    output logic          frame_end
);
    localparam int TW = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    sh_state_t     state, state_nx;
    logic [TW-1:0] tcnt;
    logic [IW-1:0] bidx;
    logic [DW-1:0] shreg;
    logic          bit_last;

    assign bit_last = tick && (tcnt == TW'(BIT_TICKS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE:  if (src_valid) state_nx = SH_START;
            SH_START: if (bit_last)  state_nx = SH_DATA;
            SH_DATA:  if (bit_last && bidx == IW'(DW - 1)) state_nx = SH_STOP;
            SH_STOP:  if (bit_last)  state_nx = src_valid ? SH_START : SH_IDLE;
            default:  state_nx = SH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        txd       = 1'b1;
        src_take  = 1'b0;
        frame_end = 1'b0;
        unique case (state)
            SH_IDLE:  src_take = src_valid;
            SH_START: txd = 1'b0;
            SH_DATA:  txd = shreg[0];
            SH_STOP: begin
                frame_end = bit_last;
                src_take  = bit_last && src_valid;
            end
            default: txd = 1'b1;
        endcase
    end

    assign busy = (state != SH_IDLE);

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else if (src_take) begin
            shreg <= src_data;
            tcnt  <= '0;
            bidx  <= '0;
        end else if (state != SH_IDLE && tick) begin
            if (bit_last) begin
                tcnt <= '0;
                if (state == SH_DATA) begin
                    shreg <= shreg >> 1;
                    bidx  <= bidx + 1'b1;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R2: no frame progress without a baud tick
    p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && state != SH_IDLE) |=> ($stable(state) && $stable(txd)));
    // R3: a frame only starts when a byte was offered
    p_start_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(src_valid));

endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags
    import utx_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DEPTH     = 8,
    parameter int BIT_TICKS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          fifo_mode,
    input  logic [2:0]    thr_sel,
    input  logic          ie_empty,
    input  logic          ie_notfull,
    input  logic          ie_fifo_empty,
    input  logic          ie_thr,
    input  logic          ie_done,
    output logic          txd,
    output logic          flag_empty,
    output logic          flag_notfull,
    output logic          flag_fifo_empty,
    output logic          flag_thr,
    output logic          flag_done,
    output logic          flag_ovf,
    output logic          irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          hold_valid;
    logic [DW-1:0] hold_data;
    logic          f_push, f_pop, f_full, f_empty;
    logic [DW-1:0] f_dout;
    logic [CW-1:0] f_count, f_free;
    logic          sh_take, sh_busy, sh_end, sh_valid;
    logic [DW-1:0] sh_data;
    logic          buf_empty, direct, buf_accept, accepted, buf_pop;

    assign buf_empty  = fifo_mode ? f_empty : !hold_valid;
    assign direct     = wr_en && !sh_busy && buf_empty;
    assign buf_accept = wr_en && !direct && (fifo_mode ? !f_full : !hold_valid);
    assign accepted   = direct || buf_accept;
    assign sh_valid   = !buf_empty || direct;
    assign sh_data    = !buf_empty ? (fifo_mode ? f_dout : hold_data) : wr_data;
    assign buf_pop    = sh_take && !buf_empty;

    assign f_push = fifo_mode && buf_accept;
    assign f_pop  = fifo_mode && buf_pop;

    utx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .din   (wr_data),
        .pop   (f_pop),
        .dout  (f_dout),
        .count (f_count),
        .full  (f_full),
        .empty (f_empty)
    );

    utx_shifter #(.DW(DW), .BIT_TICKS(BIT_TICKS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .src_valid (sh_valid),
        .src_data  (sh_data),
        .src_take  (sh_take),
        .txd       (txd),
        .busy      (sh_busy),
        .frame_end (sh_end)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
            flag_done  <= 1'b1;
            flag_ovf   <= 1'b0;
        end else begin
            if (!fifo_mode && buf_pop)    hold_valid <= 1'b0;
            if (!fifo_mode && buf_accept) begin
                hold_valid <= 1'b1;
                hold_data  <= wr_data;
            end
            if (accepted)                     flag_done <= 1'b0;
            else if (sh_end && buf_empty)     flag_done <= 1'b1;
            if (wr_en && !accepted)           flag_ovf  <= 1'b1;
        end
    end

    assign f_free          = CW'(DEPTH) - f_count;
    assign flag_empty      = buf_empty;
    assign flag_notfull    = !f_full;
    assign flag_fifo_empty = f_empty;
    assign flag_thr        = (f_free >= CW'(thr_slots(thr_sel, DEPTH)));
    assign irq = (flag_empty & ie_empty) | (flag_notfull & ie_notfull) |
                 (flag_fifo_empty & ie_fifo_empty) | (flag_thr & ie_thr) |
                 (flag_done & ie_done);

    // R9: complete means the serialiser is idle with nothing buffered
    p_done_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_done |-> (!sh_busy && buf_empty));
    // R9: an accepted write clears the complete flag
    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sh_busy && buf_empty) |=> (!flag_done && sh_busy));
    // R11: overflow only ever rises after a write
    p_ovf_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovf) |-> $past(wr_en));
    // R5: a write onto an occupied holding register is flagged
    p_hold_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && hold_valid && wr_en && !sh_take) |=> flag_ovf);

endmodule

// File: tb/tb_uart_tx_flags.sv
module tb_uart_tx_flags;
    logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b1, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic fifo_mode = 1'b0;
    logic [2:0] thr_sel = '0;
    logic ie_empty = 0, ie_notfull = 0, ie_fifo_empty = 0, ie_thr = 0, ie_done = 0;
    logic txd, flag_empty, flag_notfull, flag_fifo_empty, flag_thr, flag_done, flag_ovf, irq;

    int total = 0, bad = 0;
    logic dec_on = 1'b1;
    logic [7:0] exp_q[$];
    logic [7:0] rx_q[$];

    always #10 clk = ~clk;

    uart_tx_flags dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_mode(fifo_mode), .thr_sel(thr_sel), .ie_empty(ie_empty), .ie_notfull(ie_notfull),
        .ie_fifo_empty(ie_fifo_empty), .ie_thr(ie_thr), .ie_done(ie_done), .txd(txd),
        .flag_empty(flag_empty), .flag_notfull(flag_notfull), .flag_fifo_empty(flag_fifo_empty),
        .flag_thr(flag_thr), .flag_done(flag_done), .flag_ovf(flag_ovf), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [2:0] s);
        case (s)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 6;
            3'd4: return 7;
            default: return 8;
        endcase
    endfunction

    function automatic logic irq_of(input logic e, input logic nf, input logic fe,
                                    input logic th, input logic dn);
        return (e & ie_empty) | (nf & ie_notfull) | (fe & ie_fifo_empty) | (th & ie_thr) | (dn & ie_done);
    endfunction

    // serial decoder, sampling mid-bit with one tick per cycle
    initial begin
        logic prev;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (dec_on && prev && !txd) begin
                logic [7:0] b;
                repeat (8) @(negedge clk);
                chk("R2 start bit", int'(txd), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (16) @(negedge clk);
                    b[i] = txd;
                end
                repeat (16) @(negedge clk);
                chk("R2 stop bit", int'(txd), 1);
                rx_q.push_back(b);
                prev = 1'b1;
            end else begin
                prev = txd;
            end
        end
    end

    task automatic do_reset();
        wr_en = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        exp_q.delete();
        rx_q.delete();
        rst_n = 1;
        @(negedge clk);
    endtask

    // burst of k back-to-back writes started from an idle, empty block
    task automatic burst(input logic mode, input int k, input logic [2:0] ts);
        int c, kept;
        fifo_mode = mode;
        thr_sel = ts;
        kept = 0;
        for (int j = 0; j < k; j++) begin
            logic [7:0] d;
            d = 8'($urandom);
            wr_en = 1;
            wr_data = d;
            if (j == 0 || (mode && j <= 8) || (!mode && j == 1)) begin
                exp_q.push_back(d);
                kept++;
            end
            @(negedge clk);
            if (j == 0) begin
                chk("R3 txd low after direct write", int'(txd), 0);
                chk("R9 done cleared by write", int'(flag_done), 0);
            end
        end
        wr_en = 0;
        #1;
        c = kept - 1;
        if (mode) begin
            chk("R8 fifo empty after burst", int'(flag_fifo_empty), int'(c == 0));
            chk("R6 notfull after burst", int'(flag_notfull), int'(c < 8));
            chk("R7 threshold after burst", int'(flag_thr), int'((8 - c) >= thr_of(ts)));
            chk("R3/R6 empty after burst", int'(flag_empty), int'(c == 0));
        end else begin
            chk("R4 empty after burst", int'(flag_empty), int'(c == 0));
            chk("R8 fifo unused", int'(flag_fifo_empty), 1);
        end
        chk("R11 ovf after burst", int'(flag_ovf), int'(kept < k));
        chk("R10 irq after burst", int'(irq),
            int'(irq_of(flag_empty, flag_notfull, flag_fifo_empty, flag_thr, 1'b0)));
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (!flag_done && n < 4000) begin
            @(negedge clk);
            n++;
        end
        #1;
        chk("R9 done reached", int'(flag_done), 1);
        chk("R9/R6 frames sent before done", rx_q.size(), exp_q.size());
        while (exp_q.size() != 0 && rx_q.size() != 0) begin
            logic [7:0] e, r;
            e = exp_q.pop_front();
            r = rx_q.pop_front();
            chk("R2/R6 byte order and value", int'(r), int'(e));
        end
        exp_q.delete();
        rx_q.delete();
        chk("R4 empty after drain", int'(flag_empty), 1);
        chk("R8 fifo empty after drain", int'(flag_fifo_empty), 1);
        chk("R7 threshold after drain", int'(flag_thr), 1);
        chk("R10 irq after drain", int'(irq), int'(irq_of(1, 1, 1, 1, 1)));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        do_reset();
        // R1 reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 empty", int'(flag_empty), 1);
        chk("R1 notfull", int'(flag_notfull), 1);
        chk("R1 fifo empty", int'(flag_fifo_empty), 1);
        chk("R1 thr", int'(flag_thr), 1);
        chk("R1 done", int'(flag_done), 1);
        chk("R1 ovf", int'(flag_ovf), 0);
        chk("R10 irq masked", int'(irq), 0);
        ie_done = 1; #1;
        chk("R10 irq on done", int'(irq), 1);
        ie_done = 0;

        // directed: single writes, holding register, queue thresholds
        burst(1'b0, 1, 3'd0); drain();
        burst(1'b0, 2, 3'd0); drain();
        burst(1'b1, 5, 3'd3); drain();
        burst(1'b1, 8, 3'd4); drain();

        // random bursts without overflow
        for (int t = 0; t < 14; t++) begin
            logic m;
            m = 1'($urandom);
            {ie_empty, ie_notfull, ie_fifo_empty, ie_thr, ie_done} = 5'($urandom);
            burst(m, m ? 1 + int'($urandom % 9) : 1 + int'($urandom % 2), 3'($urandom));
            drain();
        end

        // R11 queue overflow, then R5 holding register overflow
        do_reset();
        ie_thr = 1; ie_notfull = 0; ie_empty = 0; ie_fifo_empty = 0; ie_done = 0;
        burst(1'b1, 11, 3'd0); drain();
        chk("R11 ovf sticky", int'(flag_ovf), 1);
        do_reset();
        burst(1'b0, 3, 3'd0); drain();
        chk("R5 ovf after hold drop", int'(flag_ovf), 1);

        // R2 no progress without baud tick
        do_reset();
        dec_on = 0;
        baud_tick = 0;
        wr_en = 1; wr_data = 8'h5a;
        @(negedge clk);
        wr_en = 0;
        repeat (40) @(negedge clk);
        chk("R2 held in start bit", int'(txd), 0);
        chk("R9 not done while held", int'(flag_done), 0);
        baud_tick = 1;
        repeat (200) @(negedge clk);
        chk("R9 done after release", int'(flag_done), 1);
        dec_on = 1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule